// File: doc/BRIEF.md
# Instruction folding group detector

This block sits at the decode edge of a stack-machine pipeline. Each cycle it looks at up to four leading instructions, each described by a one-hot class code and a candidate-valid bit. It decides whether several of them can issue together as one folded operation. If they can, it reports which of nine fixed patterns they form and how many instructions are consumed. Opcode-to-class decoding happens upstream and is not part of this block.

Folding is gated by a global enable, which the block computes itself. Folding requires four things: a status enable bit, no squash request, no possible stack-cache miss, and no window byte that is both valid and dirty. The stack-cache check is deliberately pessimistic. It compares the local-variable base against the stack-bottom register without adding any offset, and it only counts when an operand slot actually reads local variables.

All results are registered for the next pipeline stage. A stage hold freezes them, and a kill clears them.

Top module: `fold_group_detect`

## Requirements
- R1: The class code of slot k sits in `cand_type_i[6k+5:6k]` and is one-hot: bit0 not foldable, bit1 local-variable load (LV), bit2 operation (OP), bit3 group break 2 (BG2), bit4 group break 1 (BG1), bit5 memory store (MEM). `grp_o[g-1]` flags group g of this table: 1 LV LV MEM OP, 2 LV LV OP, 3 LV LV BG2, 4 LV OP MEM, 5 LV BG2, 6 LV BG1, 7 LV OP, 8 LV MEM, 9 OP MEM. Pattern position p is matched against slot p.
- R2: A group matches only if every slot it spans has its `cand_vld_i` bit set.
- R3: Longer patterns win over shorter ones, and table order decides among patterns of equal length. At most one group flag is set.
- R4: `cnt_o` is one-hot, and bit n means n+1 instructions issue. Group 1 issues 4, groups 2 to 4 issue 3, and groups 5 to 9 issue 2.
- R5: When no group matches and slot 0 is valid, exactly one instruction issues (`cnt_o`=0001) and all group flags are zero.
- R6: When slot 0 is invalid, `nv_o` is 1, and `cnt_o`, `grp_o`, `fold_o` and `nofold_o` are all zero.
- R7: Folding needs `fold_en_i`=1 and `squash_i`=0. Otherwise the result is the single-issue or not-valid outcome.
- R8: Folding is blocked when `lv_base_i` > `stk_bottom_i` (unsigned) and some bit of `lv_acc_i` is set. Equal values, or no local-variable access, do not block folding.
- R9: Folding is blocked when any window byte has both `byte_vld_i` and `byte_dirty_i` set. A dirty byte that is not valid has no effect.
- R10: `fold_o` is 1 exactly when 2 to 4 instructions issue. `nofold_o` is 1 exactly when one instruction issues.
- R11: Outputs appear one clock after their inputs. With `kill_i`=1, every output loads zero on the next edge.
- R12: With `hold_i`=1 and `kill_i`=0, every output keeps its value. Kill overrides hold.
- R13: While `rst_n` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cand_type_i | input | 24 | One-hot class codes of four slots |
| cand_vld_i | input | 4 | Candidate-valid per slot |
| fold_en_i | input | 1 | Status enable bit for folding |
| squash_i | input | 1 | Pipeline request to suppress folding |
| lv_base_i | input | 32 | Local-variable base address |
| stk_bottom_i | input | 32 | Stack-bottom register |
| lv_acc_i | input | 2 | Operand slots that read local variables |
| byte_vld_i | input | 7 | Valid bits of the fetch window |
| byte_dirty_i | input | 7 | Dirty bits of the fetch window |
| kill_i | input | 1 | Clear registered results |
| hold_i | input | 1 | Freeze registered results |
| grp_o | output | 9 | Registered group flags |
| cnt_o | output | 4 | Registered one-hot issue count |
| fold_o | output | 1 | Two or more instructions issue |
| nofold_o | output | 1 | Exactly one instruction issues |
| nv_o | output | 1 | Slot 0 invalid |

## Verification
Kill and hold can both be asserted in the same cycle, and kill must win. The bench drives them together, both directly after a folded result and in random traffic at low rates. It checks that the next sample is all zeros and not the frozen value. Patterns that share a prefix, such as LV OP MEM against LV OP, also meet in one cycle. These are driven in both directed and biased random stimulus, and the result is compared against an independent reference that walks the pattern table in priority order.

// File: rtl/fgd_pkg.sv
package fgd_pkg;
  localparam int TYPE_W = 6;
  localparam int NSLOT  = 4;
  localparam int NGRP   = 9;

  // class bit positions within a type code
  localparam int C_NF  = 0;
  localparam int C_LV  = 1;
  localparam int C_OP  = 2;
  localparam int C_BG2 = 3;
  localparam int C_BG1 = 4;
  localparam int C_MEM = 5;

  // pattern length per group index (0-based, priority order)
  function automatic int pat_len(input int g);
    case (g)
      0:       return 4;
      1, 2, 3: return 3;
      default: return 2;
    endcase
  endfunction

  // class bit expected at position p of group g
  function automatic int pat_cls(input int g, input int p);
    case (g)
      0: case (p) 0: return C_LV; 1: return C_LV; 2: return C_MEM; default: return C_OP;  endcase
      1: case (p) 0: return C_LV; 1: return C_LV; default: return C_OP;  endcase
      2: case (p) 0: return C_LV; 1: return C_LV; default: return C_BG2; endcase
      3: case (p) 0: return C_LV; 1: return C_OP; default: return C_MEM; endcase
      4: return (p == 0) ? C_LV : C_BG2;
      5: return (p == 0) ? C_LV : C_BG1;
      6: return (p == 0) ? C_LV : C_OP;
      7: return (p == 0) ? C_LV : C_MEM;
      default: return (p == 0) ? C_OP : C_MEM;
    endcase
  endfunction
endpackage

// File: rtl/fgd_enable.sv
module fgd_enable #(
  parameter int WIN_BYTES = 7,
  parameter int ADDR_W    = 32,
  parameter int ACC_SLOTS = 2
) (
  input  logic                 fold_en_i,
  input  logic                 squash_i,
  input  logic [ADDR_W-1:0]    lv_base_i,
  input  logic [ADDR_W-1:0]    stk_bottom_i,
  input  logic [ACC_SLOTS-1:0] lv_acc_i,
  input  logic [WIN_BYTES-1:0] byte_vld_i,
  input  logic [WIN_BYTES-1:0] byte_dirty_i,
  output logic                 en_o
);
  logic [WIN_BYTES-1:0] stale;
  logic                 any_stale;
  logic                 sc_miss;

  for (genvar b = 0; b < WIN_BYTES; b++) begin : g_byte
    assign stale[b] = byte_vld_i[b] & byte_dirty_i[b];
  end

  assign any_stale = |stale;
  assign sc_miss   = (lv_base_i > stk_bottom_i) & (|lv_acc_i);
  assign en_o      = fold_en_i & ~squash_i & ~sc_miss & ~any_stale;
endmodule

// File: rtl/fgd_match.sv
module fgd_match
  import fgd_pkg::*;
(
  input  logic [NSLOT*TYPE_W-1:0] type_i,
  input  logic [NSLOT-1:0]        vld_i,
  input  logic                    en_i,
  output logic [NGRP-1:0]         grp_o,
  output logic [NSLOT-1:0]        cnt_o,
  output logic                    nv_o
);
  logic [NGRP-1:0] hit;

  for (genvar g = 0; g < NGRP; g++) begin : g_pat
    localparam int LEN = pat_len(g);
    logic [LEN-1:0] pos_ok;
    for (genvar p = 0; p < LEN; p++) begin : g_pos
      assign pos_ok[p] = vld_i[p] & type_i[p*TYPE_W + pat_cls(g, p)];
    end
    assign hit[g] = en_i & (&pos_ok);
  end

  always_comb begin
    logic taken;
    int   wlen;
    grp_o = '0;
    cnt_o = '0;
    nv_o  = 1'b0;
    taken = 1'b0;
    wlen  = 1;
    for (int g = 0; g < NGRP; g++) begin
      if (hit[g] && !taken) begin
        grp_o[g] = 1'b1;
        taken    = 1'b1;
        wlen     = pat_len(g);
      end
    end
    if (!vld_i[0]) begin
      grp_o = '0;
      nv_o  = 1'b1;
    end else begin
      cnt_o[wlen-1] = 1'b1;
    end
  end
endmodule

// File: rtl/fgd_regs.sv
module fgd_regs
  import fgd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kill_i,
  input  logic             hold_i,
  input  logic [NGRP-1:0]  grp_d,
  input  logic [NSLOT-1:0] cnt_d,
  input  logic             nv_d,
  output logic [NGRP-1:0]  grp_q,
  output logic [NSLOT-1:0] cnt_q,
  output logic             fold_q,
  output logic             nofold_q,
  output logic             nv_q
);
  logic             load;
  logic [NGRP-1:0]  grp_n;
  logic [NSLOT-1:0] cnt_n;
  logic             fold_n, nofold_n, nv_n;

  assign load = ~hold_i | kill_i;

  always_comb begin
    grp_n    = grp_d;
    cnt_n    = cnt_d;
    fold_n   = |cnt_d[NSLOT-1:1];
    nofold_n = cnt_d[0];
    nv_n     = nv_d;
    if (kill_i) begin
      grp_n    = '0;
      cnt_n    = '0;
      fold_n   = 1'b0;
      nofold_n = 1'b0;
      nv_n     = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_q    <= '0;
      cnt_q    <= '0;
      fold_q   <= 1'b0;
      nofold_q <= 1'b0;
      nv_q     <= 1'b0;
    end else if (load) begin
      grp_q    <= grp_n;
      cnt_q    <= cnt_n;
      fold_q   <= fold_n;
      nofold_q <= nofold_n;
      nv_q     <= nv_n;
    end
  end
endmodule

// File: rtl/fold_group_detect.sv
module fold_group_detect
  import fgd_pkg::*;
#(
  parameter int WIN_BYTES = 7,
  parameter int ADDR_W    = 32,
  parameter int ACC_SLOTS = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NSLOT*TYPE_W-1:0]   cand_type_i,
  input  logic [NSLOT-1:0]          cand_vld_i,
  input  logic                      fold_en_i,
  input  logic                      squash_i,
  input  logic [ADDR_W-1:0]         lv_base_i,
  input  logic [ADDR_W-1:0]         stk_bottom_i,
  input  logic [ACC_SLOTS-1:0]      lv_acc_i,
  input  logic [WIN_BYTES-1:0]      byte_vld_i,
  input  logic [WIN_BYTES-1:0]      byte_dirty_i,
  input  logic                      kill_i,
  input  logic                      hold_i,
  output logic [NGRP-1:0]           grp_o,
  output logic [NSLOT-1:0]          cnt_o,
  output logic                      fold_o,
  output logic                      nofold_o,
  output logic                      nv_o
);
  logic             en;
  logic [NGRP-1:0]  grp_c;
  logic [NSLOT-1:0] cnt_c;
  logic             nv_c;

  fgd_enable #(.WIN_BYTES(WIN_BYTES), .ADDR_W(ADDR_W), .ACC_SLOTS(ACC_SLOTS)) en_i (
    .fold_en_i(fold_en_i), .squash_i(squash_i), .lv_base_i(lv_base_i),
    .stk_bottom_i(stk_bottom_i), .lv_acc_i(lv_acc_i), .byte_vld_i(byte_vld_i),
    .byte_dirty_i(byte_dirty_i), .en_o(en));

  fgd_match match_i (
    .type_i(cand_type_i), .vld_i(cand_vld_i), .en_i(en),
    .grp_o(grp_c), .cnt_o(cnt_c), .nv_o(nv_c));

  fgd_regs regs_i (
    .clk(clk), .rst_n(rst_n), .kill_i(kill_i), .hold_i(hold_i),
    .grp_d(grp_c), .cnt_d(cnt_c), .nv_d(nv_c),
    .grp_q(grp_o), .cnt_q(cnt_o), .fold_q(fold_o), .nofold_q(nofold_o), .nv_q(nv_o));
endmodule

// File: rtl/fgd_chk.sv
module fgd_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       kill_i,
  input logic       hold_i,
  input logic       fold_en_i,
  input logic [8:0] grp_o,
  input logic [3:0] cnt_o,
  input logic       fold_o,
  input logic       nofold_o,
  input logic       nv_o
);
  // R3
  grp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(grp_o));
  // R4
  cnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(cnt_o));
  // R10
  grp_fold_chk: assert property (@(posedge clk) disable iff (!rst_n) (|grp_o) |-> (fold_o && !nofold_o));
  // R6
  nv_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nv_o |-> (cnt_o == 4'b0 && grp_o == 9'b0 && !fold_o && !nofold_o));
  // R11
  kill_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kill_i |=> (grp_o == 9'b0 && cnt_o == 4'b0 && !nv_o && !fold_o && !nofold_o));
  // R12
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_i && !kill_i) |=> ($stable(grp_o) && $stable(cnt_o) && $stable(nv_o)));
  // R7
  no_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fold_en_i && !hold_i) |=> (grp_o == 9'b0 && !fold_o));
endmodule

bind fold_group_detect fgd_chk chk_i (
  .clk(clk), .rst_n(rst_n), .kill_i(kill_i), .hold_i(hold_i), .fold_en_i(fold_en_i),
  .grp_o(grp_o), .cnt_o(cnt_o), .fold_o(fold_o), .nofold_o(nofold_o), .nv_o(nv_o));

// File: tb/fold_group_detect_tb_top.sv
`timescale 1ns/1ps
module fold_group_detect_tb_top;
  localparam logic [5:0] NF = 6'b000001, LV = 6'b000010, OP = 6'b000100,
                         B2 = 6'b001000, B1 = 6'b010000, MM = 6'b100000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [23:0] cand_type_i;
  logic [3:0]  cand_vld_i;
  logic        fold_en_i, squash_i, kill_i, hold_i;
  logic [31:0] lv_base_i, stk_bottom_i;
  logic [1:0]  lv_acc_i;
  logic [6:0]  byte_vld_i, byte_dirty_i;
  logic [8:0]  grp_o;
  logic [3:0]  cnt_o;
  logic        fold_o, nofold_o, nv_o;

  int n_chk = 0, n_fail = 0;
  logic [15:0] exp_q;

  always #2 clk = ~clk;

  fold_group_detect dut_i (
    .clk(clk), .rst_n(rst_n), .cand_type_i(cand_type_i), .cand_vld_i(cand_vld_i),
    .fold_en_i(fold_en_i), .squash_i(squash_i), .lv_base_i(lv_base_i),
    .stk_bottom_i(stk_bottom_i), .lv_acc_i(lv_acc_i), .byte_vld_i(byte_vld_i),
    .byte_dirty_i(byte_dirty_i), .kill_i(kill_i), .hold_i(hold_i),
    .grp_o(grp_o), .cnt_o(cnt_o), .fold_o(fold_o), .nofold_o(nofold_o), .nv_o(nv_o));

  // returns {nv, fold, nofold, cnt[3:0], grp[8:0]}
  function automatic logic [15:0] model(input logic [5:0] t0, t1, t2, t3,
                                        input logic [3:0] v, input logic en);
    int g = 0;
    logic [3:0] c;
    logic [8:0] gv;
    if (!v[0]) return 16'h8000;
    if (en) begin
      if (v[3:0] == 4'hF && t0 == LV && t1 == LV && t2 == MM && t3 == OP) g = 1;
      else if (v[2:0] == 3'h7 && t0 == LV && t1 == LV && t2 == OP) g = 2;
      else if (v[2:0] == 3'h7 && t0 == LV && t1 == LV && t2 == B2) g = 3;
      else if (v[2:0] == 3'h7 && t0 == LV && t1 == OP && t2 == MM) g = 4;
      else if (v[1:0] == 2'h3 && t0 == LV && t1 == B2) g = 5;
      else if (v[1:0] == 2'h3 && t0 == LV && t1 == B1) g = 6;
      else if (v[1:0] == 2'h3 && t0 == LV && t1 == OP) g = 7;
      else if (v[1:0] == 2'h3 && t0 == LV && t1 == MM) g = 8;
      else if (v[1:0] == 2'h3 && t0 == OP && t1 == MM) g = 9;
    end
    gv = (g == 0) ? 9'b0 : (9'b1 << (g - 1));
    c  = (g == 0) ? 4'b0001 : (g == 1) ? 4'b1000 : (g <= 4) ? 4'b0100 : 4'b0010;
    return {1'b0, (c != 4'b0001), (c == 4'b0001), c, gv};
  endfunction

  function automatic logic cur_en();
    return fold_en_i && !squash_i && !((lv_base_i > stk_bottom_i) && (lv_acc_i != 0))
           && ((byte_vld_i & byte_dirty_i) == 7'b0);
  endfunction

  task automatic check(input string tag);
    logic [15:0] act = {nv_o, fold_o, nofold_o, cnt_o, grp_o};
    n_chk++;
    if (act !== exp_q) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp_q);
    end
  endtask

  // apply current inputs over one edge, then check at the following negedge
  task automatic step(input string tag);
    logic [15:0] nxt = model(cand_type_i[5:0], cand_type_i[11:6], cand_type_i[17:12],
                             cand_type_i[23:18], cand_vld_i, cur_en());
    if (kill_i) exp_q = 16'h0;
    else if (!hold_i) exp_q = nxt;
    @(posedge clk);
    @(negedge clk);
    check(tag);
  endtask

  task automatic setp(input logic [5:0] t0, t1, t2, t3, input logic [3:0] v);
    cand_type_i = {t3, t2, t1, t0};
    cand_vld_i  = v;
  endtask

  task automatic clean();
    fold_en_i = 1; squash_i = 0; kill_i = 0; hold_i = 0;
    lv_base_i = 32'h100; stk_bottom_i = 32'h200; lv_acc_i = 2'b11;
    byte_vld_i = 7'h7F; byte_dirty_i = 7'h00;
  endtask

  function automatic logic [5:0] rnd_cls();
    case ($urandom_range(0, 9))
      0, 1, 2, 3: return LV;
      4, 5:       return OP;
      6, 7:       return MM;
      8:          return ($urandom_range(0, 1) != 0) ? B1 : B2;
      default:    return NF;
    endcase
  endfunction

  initial begin
    #(4 * 150000);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    clean();
    setp(LV, LV, MM, OP, 4'hF);
    rst_n = 0; exp_q = 16'h0;
    repeat (3) @(negedge clk);
    check("R13 reset");
    rst_n = 1;
    @(negedge clk);

    setp(LV, LV, MM, OP, 4'hF); step("R1 R4 group1 count4");
    setp(LV, LV, MM, OP, 4'h7); step("R2 R5 slot3 invalid");
    setp(LV, LV, OP, NF, 4'h7); step("R4 group2");
    setp(LV, LV, B2, NF, 4'h7); step("R1 group3");
    setp(LV, OP, MM, NF, 4'h7); step("R3 group4 over group7");
    setp(LV, OP, MM, NF, 4'h3); step("R2 R3 group7 when slot2 invalid");
    setp(LV, B2, OP, NF, 4'hF); step("R1 group5");
    setp(LV, B1, OP, NF, 4'hF); step("R1 group6");
    setp(LV, MM, OP, NF, 4'hF); step("R1 group8");
    setp(OP, MM, LV, NF, 4'hF); step("R1 group9");
    setp(NF, LV, LV, OP, 4'hF); step("R5 nonfoldable lead");
    setp(LV, LV, OP, NF, 4'hE); step("R6 slot0 invalid");
    setp(LV, LV, OP, NF, 4'hF);
    fold_en_i = 0; step("R7 enable off");
    fold_en_i = 1; squash_i = 1; step("R7 squash");
    squash_i = 0; lv_base_i = 32'h300; lv_acc_i = 2'b10; step("R8 miss with access");
    lv_acc_i = 2'b00; step("R8 miss without access");
    lv_base_i = 32'h200; lv_acc_i = 2'b11; step("R8 equal bound");
    byte_dirty_i = 7'h40; step("R9 dirty valid byte");
    byte_vld_i = 7'h3F; step("R9 dirty invalid byte");
    clean();
    setp(OP, MM, NF, NF, 4'hF); hold_i = 1; step("R12 hold keeps");
    kill_i = 1; step("R12 kill beats hold");
    hold_i = 0; setp(LV, LV, OP, NF, 4'hF); kill_i = 0; step("R11 reload");
    kill_i = 1; step("R11 kill clears");
    kill_i = 0;

    for (int i = 0; i < 4000; i++) begin
      setp(rnd_cls(), rnd_cls(), rnd_cls(), rnd_cls(),
           ($urandom_range(0, 7) == 0) ? 4'($urandom()) : 4'hF);
      fold_en_i    = ($urandom_range(0, 9) != 0);
      squash_i     = ($urandom_range(0, 9) == 0);
      lv_base_i    = 32'($urandom_range(0, 7));
      stk_bottom_i = 32'($urandom_range(0, 7));
      lv_acc_i     = 2'($urandom());
      byte_vld_i   = 7'($urandom());
      byte_dirty_i = ($urandom_range(0, 3) == 0) ? 7'($urandom()) : 7'h0;
      kill_i       = ($urandom_range(0, 19) == 0);
      hold_i       = ($urandom_range(0, 6) == 0);
      step("R10 random");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule